// File: doc/BRIEF.md
# Clock source switch controller

This block decides which of three candidate oscillators drives the system clock: the internal RC oscillator, the external crystal oscillator, or the PLL output. Software writes a requested source, together with a PLL enable and a failure-monitor enable, through a single write strobe. The switch does not happen at the moment of the write. It happens only when the requested source reports ready. If the source is not ready, the request waits as pending and completes on its own once the ready flag is seen.

When the failure monitor is enabled and the external oscillator fails, the controller moves to the internal oscillator at once. This applies whether the external oscillator drives the clock directly or feeds the PLL that does. The controller then latches a failure flag and drives a non-maskable interrupt line. The flag blocks any return to the external oscillator or the PLL until software clears it. A wake-up event from a low-power mode also forces the internal oscillator.

The glitch-free multiplexer cells, the oscillators, the PLL and the dividers are outside this block. Their behaviour reaches the block only through the ready and failure inputs.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, the active source is the internal oscillator (code 00). No switch is pending, the failure flag and `nmi_o` are low, the PLL enable is low, the failure monitor is off, and `int_force_on_o` is high.
- R2: Source codes are 00 internal, 01 external and 10 PLL. `src_o` carries the active code, and `status_o[1:0]` equals it. `status_o[2]` is high while the requested source differs from the active one. `status_o[3]` is the failure flag.
- R3: A write is captured on the first rising edge where `wr_i` is high. The active source becomes the requested source on the next edge where that source is ready. Readiness is `int_rdy_i` for internal, `ext_rdy_i` for external, and `pll_rdy_i` with the PLL enable set for PLL. Until then, `status_o[2]` stays high.
- R4: A write with source code 11 is ignored entirely. The requested source, the PLL enable and the monitor enable all keep their values.
- R5: A pulse on `ext_fail_i`, with the monitor enabled and the external oscillator active, makes the internal oscillator active on the next edge. It also sets the failure flag and raises `nmi_o`.
- R6: With the PLL active, a failure pulse causes the same fallback when `pll_ref_ext_i` is high. It has no effect when `pll_ref_ext_i` is low.
- R7: With the monitor disabled, `ext_fail_i` has no effect on the active source or on `nmi_o`.
- R8: The failure flag and `nmi_o` stay high until a `fail_clr_i` pulse arrives. While the flag is set, a request for the external oscillator or the PLL stays pending. After the clear, the request completes.
- R9: A write that clears the PLL enable while the PLL is the active source leaves `pll_en_o` high. In any other state, the write clears it.
- R10: A `wake_i` pulse makes the internal oscillator active on the next edge and cancels any pending request.
- R11: `int_force_on_o` is high whenever the internal oscillator is active or the failure flag is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Configuration write strobe |
| wr_src_i | input | 2 | Requested source code |
| wr_pll_en_i | input | 1 | Requested PLL enable |
| wr_mon_en_i | input | 1 | Requested failure-monitor enable |
| int_rdy_i | input | 1 | Internal oscillator ready |
| ext_rdy_i | input | 1 | External oscillator ready |
| pll_rdy_i | input | 1 | PLL locked |
| pll_ref_ext_i | input | 1 | PLL reference is the external oscillator |
| ext_fail_i | input | 1 | External oscillator failure pulse |
| fail_clr_i | input | 1 | Clear the failure flag |
| wake_i | input | 1 | Wake-up from a low-power mode |
| src_o | output | 2 | Active source code |
| status_o | output | 4 | {fail flag, pending, active code} |
| pll_en_o | output | 1 | PLL enable |
| int_force_on_o | output | 1 | Hardware enable for the internal oscillator |
| nmi_o | output | 1 | Non-maskable failure interrupt |

## Verification
Some rules are checked by the assertions on every cycle:
- the reserved code never becomes active;
- a move to the external oscillator or the PLL only happens after its ready flag was seen;
- a monitored failure and a wake-up both land on the internal oscillator;
- the failure flag pins the internal oscillator until it is cleared;
- the PLL enable cannot drop while the PLL is active;
- a reserved write changes nothing.

Other behaviour can only be shown by the bench's scenarios:
- a request that waits, and then completes once the ready flag rises;
- the difference a PLL reference source makes to failure handling;
- a pending request that resumes after the failure flag is cleared;
- a disabled monitor ignoring a failure.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned STAT_W = SRC_W + 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_INT = 2'b00,
    SRC_EXT = 2'b01,
    SRC_PLL = 2'b10,
    SRC_RSV = 2'b11
  } src_e;
endpackage

// File: rtl/clk_src_cfg.sv
module clk_src_cfg
  import clk_src_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  src_e wr_src_i,
  input  logic wr_pll_en_i,
  input  logic wr_mon_en_i,
  input  logic wake_i,
  input  src_e active_i,
  output src_e target_o,
  output logic pll_en_o,
  output logic mon_en_o
);
  src_e target_q;
  logic pll_en_q, mon_en_q;
  logic wr_ok;

  assign wr_ok = wr_i && (wr_src_i != SRC_RSV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= SRC_INT;
      pll_en_q <= 1'b0;
      mon_en_q <= 1'b0;
    end else begin
      if (wake_i)     target_q <= SRC_INT;
      else if (wr_ok) target_q <= wr_src_i;
      if (wr_ok) begin
        mon_en_q <= wr_mon_en_i;
        // PLL stays on while it clocks the system
        pll_en_q <= wr_pll_en_i | (active_i == SRC_PLL);
      end
    end
  end

  assign target_o = target_q;
  assign pll_en_o = pll_en_q;
  assign mon_en_o = mon_en_q;

  a_r9_pll_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i == SRC_PLL && pll_en_q) |=> pll_en_q);
  a_r4_rsv_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_src_i == SRC_RSV && !wake_i) |=>
      (target_q == $past(target_q) && pll_en_q == $past(pll_en_q) && mon_en_q == $past(mon_en_q)));
  a_r10_wake_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> target_q == SRC_INT);
endmodule

// File: rtl/clk_src_fsm.sv
module clk_src_fsm
  import clk_src_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e target_i,
  input  logic mon_en_i,
  input  logic pll_en_i,
  input  logic int_rdy_i,
  input  logic ext_rdy_i,
  input  logic pll_rdy_i,
  input  logic pll_ref_ext_i,
  input  logic ext_fail_i,
  input  logic fail_clr_i,
  input  logic wake_i,
  output src_e active_o,
  output logic fail_o
);
  src_e active_q;
  logic fail_q;
  logic tgt_rdy, ext_in_use, fail_evt, blocked;

  always_comb begin
    unique case (target_i)
      SRC_INT: tgt_rdy = int_rdy_i;
      SRC_EXT: tgt_rdy = ext_rdy_i;
      SRC_PLL: tgt_rdy = pll_rdy_i & pll_en_i;
      default: tgt_rdy = 1'b0;
    endcase
  end

  assign ext_in_use = (active_q == SRC_EXT) || (active_q == SRC_PLL && pll_ref_ext_i);
  assign fail_evt   = mon_en_i && ext_fail_i && ext_in_use;
  assign blocked    = fail_q && (target_i != SRC_INT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= SRC_INT;
      fail_q   <= 1'b0;
    end else begin
      if (wake_i || fail_evt)
        active_q <= SRC_INT;
      else if (target_i != active_q && tgt_rdy && !blocked)
        active_q <= target_i;
      if (fail_evt)        fail_q <= 1'b1;
      else if (fail_clr_i) fail_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign fail_o   = fail_q;

  a_r2_no_rsv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q != SRC_RSV);
  a_r3_ext_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q == SRC_EXT && $past(active_q) != SRC_EXT) |-> $past(ext_rdy_i));
  a_r3_pll_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q == SRC_PLL && $past(active_q) != SRC_PLL) |-> ($past(pll_rdy_i) && $past(pll_en_i)));
  a_r5_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_en_i && ext_fail_i && active_q == SRC_EXT) |=> (active_q == SRC_INT && fail_q));
  a_r8_hold_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !fail_clr_i && active_q == SRC_INT) |=> active_q == SRC_INT);
  a_r10_wake_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> active_q == SRC_INT);
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SRC_W-1:0]  wr_src_i,
  input  logic              wr_pll_en_i,
  input  logic              wr_mon_en_i,
  input  logic              int_rdy_i,
  input  logic              ext_rdy_i,
  input  logic              pll_rdy_i,
  input  logic              pll_ref_ext_i,
  input  logic              ext_fail_i,
  input  logic              fail_clr_i,
  input  logic              wake_i,
  output logic [SRC_W-1:0]  src_o,
  output logic [STAT_W-1:0] status_o,
  output logic              pll_en_o,
  output logic              int_force_on_o,
  output logic              nmi_o
);
  src_e target, active;
  logic mon_en, pll_en, fail;

  clk_src_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .wr_src_i    (src_e'(wr_src_i)),
    .wr_pll_en_i (wr_pll_en_i),
    .wr_mon_en_i (wr_mon_en_i),
    .wake_i      (wake_i),
    .active_i    (active),
    .target_o    (target),
    .pll_en_o    (pll_en),
    .mon_en_o    (mon_en)
  );

  clk_src_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .target_i      (target),
    .mon_en_i      (mon_en),
    .pll_en_i      (pll_en),
    .int_rdy_i     (int_rdy_i),
    .ext_rdy_i     (ext_rdy_i),
    .pll_rdy_i     (pll_rdy_i),
    .pll_ref_ext_i (pll_ref_ext_i),
    .ext_fail_i    (ext_fail_i),
    .fail_clr_i    (fail_clr_i),
    .wake_i        (wake_i),
    .active_o      (active),
    .fail_o        (fail)
  );

  assign src_o          = active;
  assign status_o       = {fail, target != active, active};
  assign pll_en_o       = pll_en;
  assign nmi_o          = fail;
  assign int_force_on_o = (active == SRC_INT) || fail;

  a_r11_force_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> int_force_on_o);
endmodule

// File: tb/tb_clk_src_ctrl.sv
module tb_clk_src_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, pll_en_w = 1'b0, mon_en_w = 1'b0;
  logic [1:0] wr_src = 2'b00;
  logic int_rdy = 1'b1, ext_rdy = 1'b0, pll_rdy = 1'b0, pll_ref_ext = 1'b0;
  logic ext_fail = 1'b0, fail_clr = 1'b0, wake = 1'b0;
  logic [1:0] src;
  logic [3:0] status;
  logic pll_en, int_force_on, nmi;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  clk_src_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_src_i(wr_src),
    .wr_pll_en_i(pll_en_w), .wr_mon_en_i(mon_en_w),
    .int_rdy_i(int_rdy), .ext_rdy_i(ext_rdy), .pll_rdy_i(pll_rdy),
    .pll_ref_ext_i(pll_ref_ext), .ext_fail_i(ext_fail), .fail_clr_i(fail_clr),
    .wake_i(wake), .src_o(src), .status_o(status), .pll_en_o(pll_en),
    .int_force_on_o(int_force_on), .nmi_o(nmi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [1:0] s, input logic pe, input logic me);
    wr = 1'b1; wr_src = s; pll_en_w = pe; mon_en_w = me;
    step(1);
    wr = 1'b0;
  endtask

  task automatic pulse_fail();
    ext_fail = 1'b1; step(1); ext_fail = 1'b0;
  endtask

  task automatic pulse_clr();
    fail_clr = 1'b1; step(1); fail_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 src", src, 0);
    chk("R1 status", status, 0);
    chk("R1 nmi", nmi, 0);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 force_on", int_force_on, 1);
  endtask

  task automatic t_switch_ext();
    ext_rdy = 1'b1;
    write(2'b01, 1'b0, 1'b1);
    chk("R3 not yet", src, 0);
    chk("R2 pending", status[2], 1);
    step(1);
    chk("R3 ext active", src, 1);
    chk("R2 status src", status[1:0], 1);
    chk("R2 pending clear", status[2], 0);
    chk("R11 force off", int_force_on, 0);
  endtask

  task automatic t_deferred_pll();
    pll_rdy = 1'b0; pll_ref_ext = 1'b0;
    write(2'b10, 1'b1, 1'b1);
    step(5);
    chk("R3 waits", src, 1);
    chk("R3 pending", status[2], 1);
    chk("R3 pll_en", pll_en, 1);
    pll_rdy = 1'b1;
    step(1);
    chk("R3 pll active", src, 2);
  endtask

  task automatic t_pll_refuse_and_rsv();
    write(2'b10, 1'b0, 1'b1);
    step(1);
    chk("R9 pll kept", pll_en, 1);
    write(2'b11, 1'b0, 1'b0);
    step(2);
    chk("R4 src", src, 2);
    chk("R4 pll_en", pll_en, 1);
    chk("R4 pending", status[2], 0);
    // monitor must still be on after the ignored write
    pll_ref_ext = 1'b1;
    pulse_fail();
    chk("R4 monitor kept", nmi, 1);
    pulse_clr();
    step(1);
    chk("R8 back to pll", src, 2);
  endtask

  task automatic t_pll_fail();
    pll_ref_ext = 1'b0;
    pulse_fail();
    step(1);
    chk("R6 int ref no effect", src, 2);
    chk("R6 int ref nmi", nmi, 0);
    pll_ref_ext = 1'b1;
    pulse_fail();
    chk("R6 fallback", src, 0);
    chk("R6 nmi", nmi, 1);
    chk("R2 fail bit", status[3], 1);
    chk("R11 force on", int_force_on, 1);
    step(4);
    chk("R8 held int", src, 0);
    chk("R8 held pending", status[2], 1);
    chk("R8 nmi held", nmi, 1);
    pulse_clr();
    chk("R8 nmi cleared", nmi, 0);
    step(1);
    chk("R8 resumed", src, 2);
    write(2'b00, 1'b0, 1'b1);
    chk("R9 refused while pll", pll_en, 1);
    step(1);
    chk("R3 to int", src, 0);
    write(2'b00, 1'b0, 1'b1);
    chk("R9 cleared", pll_en, 0);
  endtask

  task automatic t_ext_fail();
    write(2'b01, 1'b0, 1'b1);
    step(1);
    chk("R3 ext", src, 1);
    pulse_fail();
    chk("R5 fallback", src, 0);
    chk("R5 nmi", nmi, 1);
    write(2'b01, 1'b0, 1'b1);
    step(3);
    chk("R8 ext pending", src, 0);
    pulse_clr();
    step(1);
    chk("R8 ext resumed", src, 1);
  endtask

  task automatic t_mon_off();
    write(2'b01, 1'b0, 1'b0);
    pulse_fail();
    step(1);
    chk("R7 src kept", src, 1);
    chk("R7 no nmi", nmi, 0);
  endtask

  task automatic t_wake();
    pll_rdy = 1'b0;
    write(2'b10, 1'b1, 1'b1);
    step(2);
    chk("R10 pending before", status[2], 1);
    wake = 1'b1; step(1); wake = 1'b0;
    chk("R10 int", src, 0);
    chk("R10 pending cancelled", status[2], 0);
    chk("R11 force on wake", int_force_on, 1);
    pll_rdy = 1'b1;
    step(3);
    chk("R10 stays int", src, 0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_switch_ext();
    t_deferred_pll();
    t_pll_refuse_and_rsv();
    t_pll_fail();
    t_ext_fail();
    t_mon_off();
    t_wake();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule